// File: doc/BRIEF.md
# PSRAM Power-Mode Controller

This block decides how a pseudo-static RAM spends its standby time. An active-low standby input (`zz_n`) takes the part out of normal operation. A short configuration window follows each falling edge of that input. During the window a write on the address bus loads a five-bit mode register. Chip select (`ce_n`) and a falling edge on the write strobe (`we_n`) qualify that write. The register selects three savings. Reduced size shrinks the usable array to one half or one quarter. Partial refresh keeps only one half or one quarter refreshed during standby. Deep sleep switches refresh off entirely.

The three settings take effect at different points of the standby cycle. Partial refresh is live only while `zz_n` is low. A new reduced size is latched when `zz_n` rises, and it stays in force across later standby periods. Deep sleep begins when `zz_n` falls with the deep bit already stored. Leaving deep sleep returns every setting to its default and raises a data-lost flag. That flag stays up until the first array write.

The outputs feed the surrounding logic. An access-allowed flag guards the array. Refresh bounds and a refresh enable drive the refresh sequencer. A two-bit mode code reports the current state. There are four states. PM_ACTIVE is normal operation. PM_CFG_WIN is standby with the write window open. PM_STBY is standby after the window has closed. PM_DEEP is deep sleep. The transitions are:
- enter-window: PM_ACTIVE to PM_CFG_WIN, taken when `zz_n` falls and the deep bit is clear.
- enter-deep: PM_ACTIVE to PM_DEEP, taken when `zz_n` falls and the deep bit is set.
- window-close: PM_CFG_WIN to PM_STBY, taken after `WIN_CYC` cycles.
- wake: PM_CFG_WIN or PM_STBY to PM_ACTIVE, taken when `zz_n` rises; the reduced size is latched here.
- deep-wake: PM_DEEP to PM_ACTIVE, taken when `zz_n` rises; all settings are cleared here.

Top module: `psram_pwr_ctrl`

## Requirements
- R1: After reset the block has these outputs. `mode_st` is 0, `data_lost` is 0 and `ref_en` is 1. The refresh range is 0 to all-ones. `acc_ok` is 1 for every address.
- R2: A register write is taken only on a clock edge where all of these hold. `zz_n` is low. `ce_n` is low. `we_n` is low and was high on the previous edge. The edge is one of the first `WIN_CYC` edges after `zz_n` was first sampled low. Any other write attempt leaves the register unchanged. This includes a write with `ce_n` high or a write after the window has closed.
- R3: A write copies `addr[4:0]` into the register with these bit meanings. Bit 4 enables deep sleep. Bit 3 enables partial refresh. Bit 2 enables reduced size. Bit 1 picks a half (1) or a quarter (0). Bit 0 picks the bottom (0) or the top (1) half or quarter. The reset value is 0.
- R4: Bits 2..0 of the register are copied into the active size on the edge where `zz_n` is sampled high again after standby. In normal mode, `acc_ok` is 1 only for addresses inside the selected half or quarter. It is 1 for all addresses when reduced size is off.
- R5: The active size does not change during later standby periods. It changes only at a wake that follows a register rewrite.
- R6: In standby with bit 3 set, `mode_st` is 1. The refresh range is then limited to the selected half or quarter. Every later standby period uses the stored setting again.
- R7: In normal mode the refresh range is the full array and `mode_st` is 0. In standby with bit 3 clear, the range is also the full array and `mode_st` is 2.
- R8: When `zz_n` falls with bit 4 already stored, the block enters deep sleep. In deep sleep, `mode_st` is 3, `ref_en` is 0, and register writes are ignored.
- R9: On leaving deep sleep, the register and the active size return to 0 and `data_lost` is set.
- R10: `data_lost` stays set through standby and through register writes. It clears on the first write strobe with `ce_n` low in normal mode.
- R11: `acc_ok` is 0 whenever `mode_st` is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zz_n | input | 1 | Standby request, active low |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Array address; bits 4..0 carry register data |
| acc_ok | output | 1 | Address may be accessed |
| ref_lo | output | ADDR_W | Lowest address to refresh |
| ref_hi | output | ADDR_W | Highest address to refresh |
| ref_en | output | 1 | Internal refresh enabled |
| mode_st | output | 2 | 0 normal, 1 standby partial, 2 standby full, 3 deep sleep |
| data_lost | output | 1 | Array contents lost since deep-sleep exit |

## Verification
The bench builds the block with `ADDR_W` = 6 and `WIN_CYC` = 8. With six address bits, every address can be checked against the expected half or quarter for each of the 32 register codes. That makes the size and refresh decode fully exhaustive. The short window lets the bench reach writes after the window has closed in a few cycles. The bench also runs a full deep-sleep entry, wake and flag clear for every code with bit 4 set.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

    typedef enum logic [1:0] {
        PM_ACTIVE  = 2'd0,
        PM_CFG_WIN = 2'd1,
        PM_STBY    = 2'd2,
        PM_DEEP    = 2'd3
    } pm_state_e;

    typedef struct packed {
        logic deep_en;
        logic par_en;
        logic rms_en;
        logic size16;
        logic upper;
    } pm_cfg_t;

    localparam int CFG_W = 5;

    localparam logic [1:0] MODE_NORMAL    = 2'd0;
    localparam logic [1:0] MODE_STBY_PAR  = 2'd1;
    localparam logic [1:0] MODE_STBY_FULL = 2'd2;
    localparam logic [1:0] MODE_DEEP      = 2'd3;

endpackage

// File: rtl/psram_pwr_win_timer.sv
module psram_pwr_win_timer #(
    parameter int WIN_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic win_last
);
    localparam int CW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam logic [CW-1:0] LAST_VAL = CW'(WIN_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (!win_last) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign win_last = (cnt_q == LAST_VAL);

endmodule

// File: rtl/psram_pwr_region.sv
module psram_pwr_region #(
    parameter int AW = 21
) (
    input  logic          en,
    input  logic          size16,
    input  logic          upper,
    output logic [AW-1:0] lo,
    output logic [AW-1:0] hi
);
    localparam logic [AW-1:0] TOP_ADDR  = '1;
    localparam logic [AW-1:0] HALF_BASE = AW'(1) << (AW - 1);
    localparam logic [AW-1:0] HALF_END  = HALF_BASE - AW'(1);
    localparam logic [AW-1:0] QTR_END   = (AW'(1) << (AW - 2)) - AW'(1);
    localparam logic [AW-1:0] Q3_BASE   = TOP_ADDR - QTR_END;

    always_comb begin
        if (!en) begin
            lo = '0;
            hi = TOP_ADDR;
        end else if (size16) begin
            lo = upper ? HALF_BASE : '0;
            hi = upper ? TOP_ADDR : HALF_END;
        end else begin
            lo = upper ? Q3_BASE : '0;
            hi = upper ? TOP_ADDR : QTR_END;
        end
    end

endmodule

// File: rtl/psram_pwr_fsm.sv
module psram_pwr_fsm
    import psram_pwr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      zz_n,
    input  logic      deep_armed,
    input  logic      win_last,
    output pm_state_e state_q,
    output pm_state_e state_d
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PM_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_ACTIVE: begin
                if (!zz_n) begin
                    state_d = deep_armed ? PM_DEEP : PM_CFG_WIN;
                end
            end
            PM_CFG_WIN: begin
                if (zz_n) begin
                    state_d = PM_ACTIVE;
                end else if (win_last) begin
                    state_d = PM_STBY;
                end
            end
            PM_STBY: begin
                if (zz_n) begin
                    state_d = PM_ACTIVE;
                end
            end
            PM_DEEP: begin
                if (zz_n) begin
                    state_d = PM_ACTIVE;
                end
            end
        endcase
    end

endmodule

// File: rtl/psram_pwr_ctrl.sv
module psram_pwr_ctrl
    import psram_pwr_pkg::*;
#(
    parameter int ADDR_W  = 21,
    parameter int WIN_CYC = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              zz_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              acc_ok,
    output logic [ADDR_W-1:0] ref_lo,
    output logic [ADDR_W-1:0] ref_hi,
    output logic              ref_en,
    output logic [1:0]        mode_st,
    output logic              data_lost
);

    pm_state_e state_q, state_d;
    pm_cfg_t   cfg_q;
    logic      we_q, we_strobe, cfg_wr;
    logic      win_last, in_stby, load_size, wake_deep;
    logic      rms_en_q, size16_q, upper_q;
    logic [ADDR_W-1:0] sz_lo, sz_hi;
    logic      in_size;

    psram_pwr_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .zz_n       (zz_n),
        .deep_armed (cfg_q.deep_en),
        .win_last   (win_last),
        .state_q    (state_q),
        .state_d    (state_d)
    );

    psram_pwr_win_timer #(.WIN_CYC(WIN_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state_q == PM_CFG_WIN),
        .win_last (win_last)
    );

    assign in_stby   = (state_q == PM_CFG_WIN) || (state_q == PM_STBY);
    assign we_strobe = we_q && !we_n && !ce_n;
    assign cfg_wr    = (state_q == PM_CFG_WIN) && !zz_n && we_strobe;
    assign load_size = in_stby && (state_d == PM_ACTIVE);
    assign wake_deep = (state_q == PM_DEEP) && (state_d == PM_ACTIVE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q      <= 1'b1;
            cfg_q     <= '0;
            rms_en_q  <= 1'b0;
            size16_q  <= 1'b0;
            upper_q   <= 1'b0;
            data_lost <= 1'b0;
        end else begin
            we_q <= we_n;
            if (wake_deep) begin
                cfg_q     <= '0;
                rms_en_q  <= 1'b0;
                size16_q  <= 1'b0;
                upper_q   <= 1'b0;
                data_lost <= 1'b1;
            end else begin
                if (cfg_wr) begin
                    cfg_q <= pm_cfg_t'(addr[CFG_W-1:0]);
                end
                if (load_size) begin
                    rms_en_q <= cfg_q.rms_en;
                    size16_q <= cfg_q.size16;
                    upper_q  <= cfg_q.upper;
                end
                if ((state_q == PM_ACTIVE) && we_strobe) begin
                    data_lost <= 1'b0;
                end
            end
        end
    end

    psram_pwr_region #(.AW(ADDR_W)) u_size_rgn (
        .en     (rms_en_q),
        .size16 (size16_q),
        .upper  (upper_q),
        .lo     (sz_lo),
        .hi     (sz_hi)
    );

    psram_pwr_region #(.AW(ADDR_W)) u_ref_rgn (
        .en     (cfg_q.par_en && in_stby),
        .size16 (cfg_q.size16),
        .upper  (cfg_q.upper),
        .lo     (ref_lo),
        .hi     (ref_hi)
    );

    assign in_size = (addr >= sz_lo) && (addr <= sz_hi);

    always_comb begin
        unique case (state_q)
            PM_ACTIVE: begin
                mode_st = MODE_NORMAL;
                ref_en  = 1'b1;
                acc_ok  = in_size;
            end
            PM_CFG_WIN, PM_STBY: begin
                mode_st = cfg_q.par_en ? MODE_STBY_PAR : MODE_STBY_FULL;
                ref_en  = 1'b1;
                acc_ok  = 1'b0;
            end
            PM_DEEP: begin
                mode_st = MODE_DEEP;
                ref_en  = 1'b0;
                acc_ok  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/psram_pwr_ctrl_chk.sv
module psram_pwr_ctrl_chk #(
    parameter int AW      = 21,
    parameter int WIN_CYC = 100
) (
    input logic          clk,
    input logic          rst_n,
    input logic          zz_n,
    input logic          ce_n,
    input logic          cfg_wr,
    input logic          acc_ok,
    input logic          ref_en,
    input logic [AW-1:0] ref_lo,
    input logic [AW-1:0] ref_hi,
    input logic [1:0]    mode_st,
    input logic          data_lost
);
    localparam int LW = $clog2(WIN_CYC + 2);
    localparam logic [LW-1:0] SAT = LW'(WIN_CYC + 1);
    localparam logic [LW-1:0] WLIM = LW'(WIN_CYC);

    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (zz_n) begin
            low_cnt <= '0;
        end else if (low_cnt != SAT) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    AST_WR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |-> (low_cnt >= LW'(1) && low_cnt <= WLIM)); // R2
    AST_WR_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |-> (!zz_n && !ce_n)); // R2
    AST_DEEP_NO_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_st == 2'd3) |-> !ref_en); // R8
    AST_DEEP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_st == 2'd3) |-> !cfg_wr); // R8
    AST_NORMAL_FULL_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_st == 2'd0) |-> (ref_en && ref_lo == '0 && ref_hi == '1)); // R7
    AST_STBY_FULL_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_st == 2'd2) |-> (ref_lo == '0 && ref_hi == '1)); // R7
    AST_NO_ACCESS_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_st != 2'd0) |-> !acc_ok); // R11
    AST_DEEP_EXIT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_st == 2'd3 && zz_n) |=> (data_lost && mode_st == 2'd0)); // R9
    AST_LOST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (data_lost && mode_st != 2'd0) |=> data_lost); // R10

endmodule

bind psram_pwr_ctrl psram_pwr_ctrl_chk #(.AW(ADDR_W), .WIN_CYC(WIN_CYC)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .zz_n      (zz_n),
    .ce_n      (ce_n),
    .cfg_wr    (cfg_wr),
    .acc_ok    (acc_ok),
    .ref_en    (ref_en),
    .ref_lo    (ref_lo),
    .ref_hi    (ref_hi),
    .mode_st   (mode_st),
    .data_lost (data_lost)
);

// File: tb/psram_pwr_ctrl_tb_top.sv
`timescale 1ns/1ps
module psram_pwr_ctrl_tb_top;
    localparam int AW   = 6;
    localparam int WIN  = 8;
    localparam int MAXA = (1 << AW) - 1;

    logic clk = 1'b0;
    logic rst_n, zz_n, ce_n, we_n;
    logic [AW-1:0] addr;
    logic acc_ok, ref_en, data_lost;
    logic [AW-1:0] ref_lo, ref_hi;
    logic [1:0] mode_st;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    psram_pwr_ctrl #(.ADDR_W(AW), .WIN_CYC(WIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .zz_n(zz_n), .ce_n(ce_n), .we_n(we_n),
        .addr(addr), .acc_ok(acc_ok), .ref_lo(ref_lo), .ref_hi(ref_hi),
        .ref_en(ref_en), .mode_st(mode_st), .data_lost(data_lost)
    );

    function automatic int rgn_lo(int en, int s16, int up);
        if (en == 0 || up == 0) return 0;
        return s16 ? (1 << (AW - 1)) : (3 << (AW - 2));
    endfunction

    function automatic int rgn_hi(int en, int s16, int up);
        if (en == 0 || up != 0) return MAXA;
        return s16 ? (1 << (AW - 1)) - 1 : (1 << (AW - 2)) - 1;
    endfunction

    function automatic int exp_in(int v, int a);
        int lo, hi;
        lo = rgn_lo((v >> 2) & 1, (v >> 1) & 1, v & 1);
        hi = rgn_hi((v >> 2) & 1, (v >> 1) & 1, v & 1);
        return (a >= lo && a <= hi) ? 1 : 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; zz_n = 1'b1; ce_n = 1'b1; we_n = 1'b1; addr = '0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic pulse_write(input int a);
        ce_n = 1'b0; we_n = 1'b0; addr = AW'(a);
        step(1);
        we_n = 1'b1; ce_n = 1'b1; addr = '0;
        step(1);
    endtask

    task automatic check_acc(input int v, input string req);
        for (int a = 0; a <= MAXA; a++) begin
            addr = AW'(a);
            #0.5;
            chk(req, acc_ok, exp_in(v, a));
        end
        addr = '0;
    endtask

    // standby view for stored code v
    task automatic check_stby(input int v, input string req);
        int par;
        par = (v >> 3) & 1;
        chk(req, mode_st, par ? 1 : 2);
        chk(req, ref_lo, rgn_lo(par, (v >> 1) & 1, v & 1));
        chk(req, ref_hi, rgn_hi(par, (v >> 1) & 1, v & 1));
        chk(req, ref_en, 1);
        chk("R11", acc_ok, 0);
    endtask

    task automatic check_normal(input string req);
        chk(req, mode_st, 0);
        chk(req, ref_lo, 0);
        chk(req, ref_hi, MAXA);
        chk(req, ref_en, 1);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check_normal("R1");
        chk("R1", data_lost, 0);
        check_acc(0, "R1");

        for (int v = 0; v < 32; v++) begin
            do_reset();
            zz_n = 1'b0;
            step(1);
            check_stby(0, "R7");
            pulse_write(v);
            // R3 field positions, R6 partial refresh live while zz low
            check_stby(v, "R3/R6");
            zz_n = 1'b1;
            step(1);
            check_normal("R7");
            check_acc(v, "R4");
            zz_n = 1'b0;
            step(1);
            if ((v >> 4) & 1) begin
                chk("R8", mode_st, 3);
                chk("R8", ref_en, 0);
                chk("R11", acc_ok, 0);
            end else begin
                check_stby(v, "R6");
            end
            step(WIN + 2);
            pulse_write(v ^ 5'b01100);  // after window: ignored (R2)
            if (((v >> 4) & 1) == 0) begin
                check_stby(v, "R2");
            end
            zz_n = 1'b1;
            step(1);
            if ((v >> 4) & 1) begin
                chk("R9", data_lost, 1);
                check_normal("R9");
                check_acc(0, "R9");
                zz_n = 1'b0;
                step(1);
                check_stby(0, "R9");
                pulse_write(0);
                chk("R10", data_lost, 1);
                zz_n = 1'b1;
                step(1);
                chk("R10", data_lost, 1);
                pulse_write(0);
                chk("R10", data_lost, 0);
            end else begin
                chk("R10", data_lost, 0);
                check_acc(v, "R2/R5");
            end
        end

        // write with chip select high is ignored
        do_reset();
        zz_n = 1'b0;
        step(1);
        ce_n = 1'b1; we_n = 1'b0; addr = AW'(5'b01100);
        step(1);
        we_n = 1'b1; addr = '0;
        step(1);
        check_stby(0, "R2");
        zz_n = 1'b1;
        step(1);
        check_acc(0, "R2");

        // last edge of the window still accepts a write
        do_reset();
        zz_n = 1'b0;
        step(WIN);
        pulse_write(5'b01110);
        check_stby(5'b01110, "R2");
        zz_n = 1'b1;
        step(1);
        check_acc(5'b01110, "R4");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule